// File: doc/BRIEF.md
# Sequentially Consistent Write Buffer

This block sits behind a processor whose first-level cache is write-through and in front of a write-back second-level cache. Every store the processor makes is queued in an in-order buffer and sent to the second level one at a time, oldest first. Loads are never served from the buffer: a load takes its value from the first-level cache when it hits there, or from the second level when it misses.

The order in which loads may pass buffered stores is set by a mode input. A load that misses must wait until the buffer is fully drained, so its read reaches the second level after every older store. In strict mode a load that hits in the first level waits too, so the processor sees the whole write latency and all of its accesses stay in program order. In relaxed mode a hit may complete while stores are still queued. While a read miss is being serviced the second-level port is busy, and further loads and stores are held off until the read data has returned.

The processor has a store channel and a load channel, each with a valid/ready handshake. When both fire in one cycle the store counts as the older access. Load data comes back as a one-cycle response pulse.

Top module: `sc_store_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, `buf_empty` is 1, `buf_count` is 0, `l2_valid` is 0 and `ld_rsp_valid` is 0.
- R2: Stores are presented on the second-level port (`l2_we`=1) in the order they were accepted, with the same address and data. A new request is raised only after `l2_done` has closed the previous one.
- R3: When the buffer holds DEPTH entries, `st_ready` is 0. No accepted store is lost, and every accepted store reaches the second-level port.
- R4: A load with `l1_hit`=0 is accepted only in a cycle where the buffer is empty and no store is accepted. This holds in both modes, and only such a load raises a read (`l2_we`=0) on the second-level port.
- R5: With `strict_mode`=1, a load with `l1_hit`=1 is accepted only in a cycle where the buffer is empty and no store is accepted.
- R6: With `strict_mode`=0, a load with `l1_hit`=1 is accepted while stores are queued, provided no read miss is in flight. Its response pulse follows one cycle after acceptance.
- R7: Load data equals `l1_rdata` as presented at acceptance for a hit, or `l2_rdata` for a miss. Data still waiting in the buffer is never returned.
- R8: A store accepted in the same cycle that a load arrives at an empty buffer counts as pending for that load. With `strict_mode`=1 a hit is then refused, and a miss is refused in either mode.
- R9: From the acceptance of a read miss until its second-level read completes, `st_ready` and `ld_ready` are both 0.
- R10: `buf_count` equals the stores accepted minus the stores completed on the second-level port, and `buf_empty` is 1 exactly when `buf_count` is 0.
- R11: While `l2_valid` is 1 and `l2_ready` is 0, the request stays raised with `l2_we`, `l2_addr` and `l2_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_mode | input | 1 | 1 = strict ordering, 0 = relaxed (hits may pass stores) |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load accepted this cycle when valid |
| ld_addr | input | AW | Load address |
| l1_hit | input | 1 | First-level lookup of ld_addr hit |
| l1_rdata | input | DW | First-level data for ld_addr |
| ld_rsp_valid | output | 1 | One-cycle load response pulse |
| ld_rsp_data | output | DW | Load response data |
| l2_valid | output | 1 | Second-level request raised |
| l2_ready | input | 1 | Second-level port takes the request |
| l2_we | output | 1 | 1 = write (store drain), 0 = read (load miss) |
| l2_addr | output | AW | Second-level request address |
| l2_wdata | output | DW | Second-level write data |
| l2_done | input | 1 | Completion of the taken request |
| l2_rdata | input | DW | Read data, valid with l2_done |
| buf_empty | output | 1 | No stores queued |
| buf_count | output | $clog2(DEPTH+1) | Number of queued stores |

## Verification
Every cycle, the assertions check the occupancy arithmetic and the full-buffer back-pressure. They also check that a read reaches the second level only from an empty buffer, that strict-mode hits never pass a queued or arriving store, that only one request is outstanding, that requests stay stable under back-pressure, and that the processor side is blocked during a read miss. Only the bench scenarios can show that the drained addresses and data arrive in acceptance order, and that load data comes from the caches and not from a queued store to the same address. The same holds for a relaxed hit really completing while the second level is stalled, and for a store and a load arriving together being ordered store-first.

// File: rtl/sqb_pkg.sv
`timescale 1ns/1ps
package sqb_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_WR_REQ  = 3'd1,
        SEQ_WR_WAIT = 3'd2,
        SEQ_RD_REQ  = 3'd3,
        SEQ_RD_WAIT = 3'd4
    } seq_state_e;

    typedef enum logic {
        MODE_RELAXED = 1'b0,
        MODE_STRICT  = 1'b1
    } order_mode_e;

endpackage

// File: rtl/sqb_fifo.sv
`timescale 1ns/1ps
module sqb_fifo #(
    parameter int DEPTH = 4,
    parameter int EW    = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [EW-1:0]              push_entry,
    input  logic                       pop,
    output logic [EW-1:0]              head_entry,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic [DEPTH-1:0] wen;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_wen
        assign wen[i] = push && (s_q.wr == PW'(i));
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wen[i]) begin
                s_d.mem[i] = push_entry;
            end
        end
        if (push) begin
            s_d.wr = ptr_next(s_q.wr);
        end
        if (pop) begin
            s_d.rd = ptr_next(s_q.rd);
        end
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_entry = s_q.mem[s_q.rd];
    assign full       = (s_q.cnt == CW'(DEPTH));
    assign empty      = (s_q.cnt == '0);
    assign count      = s_q.cnt;

endmodule

// File: rtl/sqb_l2_seq.sv
`timescale 1ns/1ps
module sqb_l2_seq
    import sqb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_pending,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          rd_start,
    input  logic [AW-1:0] rd_addr,
    output logic          pop,
    output logic          rd_done,
    output logic [DW-1:0] rd_data,
    output logic          rd_busy,
    output logic          l2_valid,
    input  logic          l2_ready,
    output logic          l2_we,
    output logic [AW-1:0] l2_addr,
    output logic [DW-1:0] l2_wdata,
    input  logic          l2_done,
    input  logic [DW-1:0] l2_rdata
);
    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (wr_pending) begin
                    s_d.st   = SEQ_WR_REQ;
                    s_d.addr = head_addr;
                    s_d.data = head_data;
                end else if (rd_start) begin
                    s_d.st   = SEQ_RD_REQ;
                    s_d.addr = rd_addr;
                end
            end
            SEQ_WR_REQ:  if (l2_ready) s_d.st = SEQ_WR_WAIT;
            SEQ_WR_WAIT: if (l2_done)  s_d.st = SEQ_IDLE;
            SEQ_RD_REQ:  if (l2_ready) s_d.st = SEQ_RD_WAIT;
            SEQ_RD_WAIT: if (l2_done)  s_d.st = SEQ_IDLE;
            default:                   s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign l2_valid = (s_q.st == SEQ_WR_REQ) || (s_q.st == SEQ_RD_REQ);
    assign l2_we    = (s_q.st == SEQ_WR_REQ);
    assign l2_addr  = s_q.addr;
    assign l2_wdata = s_q.data;
    assign pop      = (s_q.st == SEQ_WR_WAIT) && l2_done;
    assign rd_done  = (s_q.st == SEQ_RD_WAIT) && l2_done;
    assign rd_data  = l2_rdata;
    assign rd_busy  = (s_q.st == SEQ_RD_REQ) || (s_q.st == SEQ_RD_WAIT);

endmodule

// File: rtl/sqb_ld_gate.sv
`timescale 1ns/1ps
module sqb_ld_gate
    import sqb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strict_mode,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic          l1_hit,
    input  logic [DW-1:0] l1_rdata,
    input  logic          fifo_empty,
    input  logic          st_fire,
    input  logic          rd_busy,
    input  logic          rd_done,
    input  logic [DW-1:0] rd_data,
    output logic          ld_ready,
    output logic          rd_start,
    output logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } rsp_t;

    rsp_t r_d, r_q;
    order_mode_e mode;
    logic stores_pending;
    logic hit_ok;
    logic miss_ok;
    logic ld_fire;

    assign mode           = order_mode_e'(strict_mode);
    assign stores_pending = !fifo_empty || st_fire;
    assign miss_ok        = !stores_pending && !rd_busy;
    assign hit_ok         = (mode == MODE_STRICT) ? (!stores_pending && !rd_busy) : !rd_busy;
    assign ld_ready       = l1_hit ? hit_ok : miss_ok;
    assign ld_fire        = ld_valid && ld_ready;
    assign rd_start       = ld_fire && !l1_hit;
    assign rd_addr        = ld_addr;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (ld_fire && l1_hit) begin
            r_d.vld  = 1'b1;
            r_d.data = l1_rdata;
        end else if (rd_done) begin
            r_d.vld  = 1'b1;
            r_d.data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.vld;
    assign rsp_data  = r_q.data;

endmodule

// File: rtl/sc_store_queue.sv
`timescale 1ns/1ps
module sc_store_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strict_mode,
    input  logic                       st_valid,
    output logic                       st_ready,
    input  logic [AW-1:0]              st_addr,
    input  logic [DW-1:0]              st_data,
    input  logic                       ld_valid,
    output logic                       ld_ready,
    input  logic [AW-1:0]              ld_addr,
    input  logic                       l1_hit,
    input  logic [DW-1:0]              l1_rdata,
    output logic                       ld_rsp_valid,
    output logic [DW-1:0]              ld_rsp_data,
    output logic                       l2_valid,
    input  logic                       l2_ready,
    output logic                       l2_we,
    output logic [AW-1:0]              l2_addr,
    output logic [DW-1:0]              l2_wdata,
    input  logic                       l2_done,
    input  logic [DW-1:0]              l2_rdata,
    output logic                       buf_empty,
    output logic [$clog2(DEPTH+1)-1:0] buf_count
);
    localparam int EW = AW + DW;

    logic          fifo_full;
    logic          fifo_empty;
    logic          st_fire;
    logic          pop;
    logic [EW-1:0] head_entry;
    logic          rd_start;
    logic [AW-1:0] rd_addr;
    logic          rd_done;
    logic [DW-1:0] rd_data;
    logic          rd_busy;

    assign st_ready  = !fifo_full && !rd_busy;
    assign st_fire   = st_valid && st_ready;
    assign buf_empty = fifo_empty;

    sqb_fifo #(
        .DEPTH (DEPTH),
        .EW    (EW)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (st_fire),
        .push_entry ({st_addr, st_data}),
        .pop        (pop),
        .head_entry (head_entry),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .count      (buf_count)
    );

    sqb_l2_seq #(
        .AW (AW),
        .DW (DW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pending (!fifo_empty),
        .head_addr  (head_entry[EW-1:DW]),
        .head_data  (head_entry[DW-1:0]),
        .rd_start   (rd_start),
        .rd_addr    (rd_addr),
        .pop        (pop),
        .rd_done    (rd_done),
        .rd_data    (rd_data),
        .rd_busy    (rd_busy),
        .l2_valid   (l2_valid),
        .l2_ready   (l2_ready),
        .l2_we      (l2_we),
        .l2_addr    (l2_addr),
        .l2_wdata   (l2_wdata),
        .l2_done    (l2_done),
        .l2_rdata   (l2_rdata)
    );

    sqb_ld_gate #(
        .AW (AW),
        .DW (DW)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .strict_mode (strict_mode),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .l1_hit      (l1_hit),
        .l1_rdata    (l1_rdata),
        .fifo_empty  (fifo_empty),
        .st_fire     (st_fire),
        .rd_busy     (rd_busy),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .ld_ready    (ld_ready),
        .rd_start    (rd_start),
        .rd_addr     (rd_addr),
        .rsp_valid   (ld_rsp_valid),
        .rsp_data    (ld_rsp_data)
    );

endmodule

// File: rtl/sqb_chk.sv
`timescale 1ns/1ps
module sqb_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       strict_mode,
    input logic                       st_valid,
    input logic                       st_ready,
    input logic                       ld_valid,
    input logic                       ld_ready,
    input logic                       l1_hit,
    input logic                       l2_valid,
    input logic                       l2_ready,
    input logic                       l2_we,
    input logic [AW-1:0]              l2_addr,
    input logic [DW-1:0]              l2_wdata,
    input logic                       l2_done,
    input logic                       buf_empty,
    input logic [$clog2(DEPTH+1)-1:0] buf_count
);
    logic wr_out;
    logic rd_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_out <= 1'b0;
            rd_out <= 1'b0;
        end else begin
            if (l2_done) begin
                wr_out <= 1'b0;
                rd_out <= 1'b0;
            end
            if (l2_valid && l2_ready) begin
                wr_out <= l2_we;
                rd_out <= !l2_we;
            end
        end
    end

    // R10
    count_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty == (buf_count == '0));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(buf_count) == int'($past(buf_count)) + int'($past(st_valid && st_ready))
                           - int'($past(l2_done && wr_out)));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(buf_count) <= DEPTH);

    // R3
    full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(buf_count) == DEPTH) |-> !st_ready);

    // R4
    miss_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid && !l2_we) |-> buf_empty);

    // R5
    strict_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_mode && l1_hit && ld_valid && ld_ready) |-> (buf_empty && !(st_valid && st_ready)));

    // R8
    same_cycle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l1_hit && ld_valid && ld_ready) |-> (buf_empty && !(st_valid && st_ready)));

    // R2
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out || rd_out) |-> !l2_valid);

    // R9
    miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |-> (!st_ready && !ld_ready));

    // R11
    l2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid && !l2_ready) |=> (l2_valid && $stable(l2_we) && $stable(l2_addr) && $stable(l2_wdata)));

endmodule

bind sc_store_queue sqb_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strict_mode (strict_mode),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .ld_valid    (ld_valid),
    .ld_ready    (ld_ready),
    .l1_hit      (l1_hit),
    .l2_valid    (l2_valid),
    .l2_ready    (l2_ready),
    .l2_we       (l2_we),
    .l2_addr     (l2_addr),
    .l2_wdata    (l2_wdata),
    .l2_done     (l2_done),
    .buf_empty   (buf_empty),
    .buf_count   (buf_count)
);

// File: tb/sc_store_queue_tb.sv
`timescale 1ns/1ps
module sc_store_queue_tb;
    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strict_mode;
    logic          st_valid;
    logic          st_ready;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic          ld_valid;
    logic          ld_ready;
    logic [AW-1:0] ld_addr;
    logic          l1_hit;
    logic [DW-1:0] l1_rdata;
    logic          ld_rsp_valid;
    logic [DW-1:0] ld_rsp_data;
    logic          l2_valid;
    logic          l2_ready;
    logic          l2_we;
    logic [AW-1:0] l2_addr;
    logic [DW-1:0] l2_wdata;
    logic          l2_done;
    logic [DW-1:0] l2_rdata;
    logic          buf_empty;
    logic [CW-1:0] buf_count;

    always #2.5 clk = ~clk;

    sc_store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .l1_hit(l1_hit), .l1_rdata(l1_rdata),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .l2_valid(l2_valid), .l2_ready(l2_ready), .l2_we(l2_we),
        .l2_addr(l2_addr), .l2_wdata(l2_wdata), .l2_done(l2_done), .l2_rdata(l2_rdata),
        .buf_empty(buf_empty), .buf_count(buf_count)
    );

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0]    l2mem [256];
    logic [AW+DW-1:0] sbq[$];
    logic [DW-1:0]    expq[$];
    bit               l2_stall = 1'b0;
    bit               rp_busy  = 1'b0;
    bit               rp_we    = 1'b0;
    bit               done_wr  = 1'b0;
    logic [AW-1:0]    rp_addr;
    logic [DW-1:0]    rp_data;
    int               rp_wait;
    int               exp_cnt;
    bit               rd_probe_st;
    bit               rd_probe_ld;

    function automatic logic [DW-1:0] l1f(input logic [AW-1:0] a);
        return {24'hC1C1C1, a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // second-level responder model
    initial begin
        l2_ready = 1'b0;
        l2_done  = 1'b0;
        l2_rdata = '0;
        forever begin
            @(negedge clk);
            l2_done  = 1'b0;
            l2_ready = 1'b0;
            if (rp_busy) begin
                if (rp_wait == 0) begin
                    l2_done = 1'b1;
                    done_wr = rp_we;
                    if (rp_we) l2mem[rp_addr] = rp_data;
                    else       l2_rdata = l2mem[rp_addr];
                    rp_busy = 1'b0;
                end else begin
                    rp_wait--;
                end
            end else if (rst_n && l2_valid && !l2_stall && ($urandom_range(0, 3) != 0)) begin
                l2_ready = 1'b1;
                rp_busy  = 1'b1;
                rp_we    = l2_we;
                rp_addr  = l2_addr;
                rp_data  = l2_wdata;
                rp_wait  = $urandom_range(0, 2);
                if (l2_we) begin
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R2", "unexpected drain write", {24'h0, l2_addr, l2_wdata}, 64'h0);
                    end else begin
                        chk({l2_addr, l2_wdata} == sbq[0], "R2", "drain order addr/data",
                            {24'h0, l2_addr, l2_wdata}, {24'h0, sbq[0]});
                        void'(sbq.pop_front());
                    end
                end
            end
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_cnt <= 0;
        else exp_cnt <= exp_cnt + int'(st_valid && st_ready) - int'(l2_done && done_wr);
    end

    // monitor, sampled just before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                chk(int'(buf_count) == exp_cnt, "R10", "buf_count", 64'(buf_count), 64'(exp_cnt));
                chk(buf_empty == (exp_cnt == 0), "R10", "buf_empty", 64'(buf_empty), 64'(exp_cnt == 0));
                if (exp_cnt == DEPTH)
                    chk(!st_ready, "R3", "st_ready when full", 64'(st_ready), 64'h0);
                if (rp_busy && !rp_we)
                    chk(!st_ready && !ld_ready, "R9", "ready during read miss",
                        64'({st_ready, ld_ready}), 64'h0);
                if (ld_rsp_valid) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R7", "unexpected response", 64'(ld_rsp_data), 64'h0);
                    end else begin
                        chk(ld_rsp_data == expq[0], "R7", "load data", 64'(ld_rsp_data), 64'(expq[0]));
                        void'(expq.pop_front());
                    end
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            st_valid = 1'b0;
            ld_valid = 1'b0;
        end
    endtask

    task automatic drain();
        int guard = 0;
        idle(1);
        while (!(buf_empty && !rp_busy && !l2_valid) && guard < 3000) begin
            idle(1);
            guard++;
        end
        idle(2);
    endtask

    // drive one cycle of requests, sample readiness, then withdraw them before the edge
    task automatic probe(input bit ds, input logic [AW-1:0] sa, input bit dl,
                         input logic [AW-1:0] la, input bit lh);
        @(negedge clk);
        st_valid = ds; st_addr = sa; st_data = 32'h0BAD0000 | 32'(sa);
        ld_valid = dl; ld_addr = la; l1_hit = lh; l1_rdata = l1f(la);
        #1;
        rd_probe_st = st_ready;
        rd_probe_ld = ld_ready;
        st_valid = 1'b0;
        ld_valid = 1'b0;
    endtask

    task automatic issue(input bit do_st, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                         input bit do_ld, input logic [AW-1:0] la, input bit lh);
        bit st_left = do_st;
        bit ld_left = do_ld;
        int guard = 0;
        bit st_acc;
        bit ld_acc;
        while ((st_left || ld_left) && guard < 3000) begin
            @(negedge clk);
            st_valid = st_left; st_addr = sa; st_data = sd;
            ld_valid = ld_left; ld_addr = la; l1_hit = lh; l1_rdata = l1f(la);
            #1;
            st_acc = st_left && st_ready;
            ld_acc = ld_left && ld_ready;
            if (st_acc) begin
                sbq.push_back({sa, sd});
                st_left = 1'b0;
            end
            if (ld_acc) begin
                if (!lh)
                    chk(buf_empty && !st_acc, "R4", "miss accepted with stores pending",
                        64'({buf_empty, st_acc}), 64'h2);
                else if (strict_mode)
                    chk(buf_empty && !st_acc, "R5", "strict hit accepted with stores pending",
                        64'({buf_empty, st_acc}), 64'h2);
                expq.push_back(lh ? l1f(la) : l2mem[la]);
                ld_left = 1'b0;
            end
            guard++;
        end
        if (guard >= 3000) chk(1'b0, "R3", "request never accepted", 64'({st_left, ld_left}), 64'h0);
    endtask

    initial begin
        void'($urandom(32'd7291));
        for (int i = 0; i < 256; i++) l2mem[i] = 32'h20000000 | 32'(i);
        rst_n = 1'b0; strict_mode = 1'b1;
        st_valid = 1'b0; st_addr = '0; st_data = '0;
        ld_valid = 1'b0; ld_addr = '0; l1_hit = 1'b0; l1_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1 during reset
        chk(buf_empty && buf_count == '0 && !l2_valid && !ld_rsp_valid, "R1", "state in reset",
            64'({buf_empty, buf_count, l2_valid, ld_rsp_valid}), 64'({1'b1, CW'(0), 2'b00}));
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(buf_empty && buf_count == '0 && !l2_valid && !ld_rsp_valid, "R1", "state after reset",
            64'({buf_empty, buf_count, l2_valid, ld_rsp_valid}), 64'({1'b1, CW'(0), 2'b00}));

        // R3: fill while the second level is stalled
        l2_stall = 1'b1;
        for (int i = 0; i < DEPTH; i++) issue(1'b1, AW'(8'h40 + i), 32'hA5000040 + i, 1'b0, '0, 1'b0);
        for (int k = 0; k < 5; k++) begin
            probe(1'b1, 8'h48, 1'b0, '0, 1'b0);
            chk(!rd_probe_st, "R3", "store refused when full", 64'(rd_probe_st), 64'h0);
        end
        l2_stall = 1'b0;
        issue(1'b1, 8'h48, 32'hA5000048, 1'b0, '0, 1'b0);
        drain();

        // R5: strict hit waits behind a queued store
        strict_mode = 1'b1;
        l2_stall = 1'b1;
        issue(1'b1, 8'h10, 32'hDEAD0010, 1'b0, '0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            probe(1'b0, '0, 1'b1, 8'h10, 1'b1);
            chk(!rd_probe_ld, "R5", "strict hit held while store queued", 64'(rd_probe_ld), 64'h0);
        end
        l2_stall = 1'b0;
        issue(1'b0, '0, '0, 1'b1, 8'h10, 1'b1);
        drain();

        // R6: relaxed hit passes a queued store, data from first level (R7)
        strict_mode = 1'b0;
        l2_stall = 1'b1;
        issue(1'b1, 8'h20, 32'hBEEF0020, 1'b0, '0, 1'b0);
        probe(1'b0, '0, 1'b1, 8'h20, 1'b1);
        chk(rd_probe_ld, "R6", "relaxed hit ready with store queued", 64'(rd_probe_ld), 64'h1);
        issue(1'b0, '0, '0, 1'b1, 8'h20, 1'b1);
        idle(3);
        chk(expq.size() == 0 && !buf_empty, "R6", "relaxed hit answered while store queued",
            64'({expq.size() == 0, buf_empty}), 64'h2);
        l2_stall = 1'b0;
        drain();

        // R8: store and load arriving together at an empty buffer
        strict_mode = 1'b1;
        l2_stall = 1'b1;
        probe(1'b1, 8'h50, 1'b1, 8'h51, 1'b1);
        chk(rd_probe_st && !rd_probe_ld, "R8", "strict same-cycle hit refused",
            64'({rd_probe_st, rd_probe_ld}), 64'h2);
        probe(1'b1, 8'h50, 1'b1, 8'h51, 1'b0);
        strict_mode = 1'b0;
        chk(!rd_probe_ld, "R8", "same-cycle miss refused", 64'(rd_probe_ld), 64'h0);
        probe(1'b1, 8'h50, 1'b1, 8'h51, 1'b1);
        chk(rd_probe_ld, "R6", "relaxed same-cycle hit accepted", 64'(rd_probe_ld), 64'h1);
        strict_mode = 1'b1;
        l2_stall = 1'b0;
        issue(1'b1, 8'h50, 32'h50505050, 1'b1, 8'h51, 1'b1);
        drain();

        // R4: relaxed miss still waits for the buffer to drain, data from second level (R7)
        strict_mode = 1'b0;
        l2_stall = 1'b1;
        issue(1'b1, 8'h30, 32'h33330030, 1'b0, '0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            probe(1'b0, '0, 1'b1, 8'h30, 1'b0);
            chk(!rd_probe_ld, "R4", "relaxed miss held while store queued", 64'(rd_probe_ld), 64'h0);
        end
        l2_stall = 1'b0;
        issue(1'b0, '0, '0, 1'b1, 8'h30, 1'b0);
        drain();
        chk(l2mem[8'h30] == 32'h33330030, "R7", "drained store visible in second level",
            64'(l2mem[8'h30]), 64'h33330030);

        // random mix
        for (int n = 0; n < 800; n++) begin
            int kind;
            if ((n % 50) == 0) strict_mode = 1'($urandom_range(0, 1));
            kind = $urandom_range(0, 6);
            if (kind <= 3)
                issue(1'b1, AW'($urandom_range(0, 15)), $urandom(), 1'b0, '0, 1'b0);
            else if (kind <= 5)
                issue(1'b0, '0, '0, 1'b1, AW'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
            else
                issue(1'b1, AW'($urandom_range(0, 15)), $urandom(),
                      1'b1, AW'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        drain();
        idle(4);
        chk(sbq.size() == 0, "R3", "every accepted store drained", 64'(sbq.size()), 64'h0);
        chk(expq.size() == 0, "R7", "every load answered", 64'(expq.size()), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule